// File: doc/BRIEF.md
# Slot Reset and Clock-Enable Sequencer

This block drives the active-low reset of a removable-card slot and the pull-down for the slot's reference-clock-enable line. It takes in the power mode chosen by the slot power controller, one within-tolerance flag per card supply rail, the host's active-low system reset, and the level read back from the clock-enable pad. The host can hold that pad low externally.

The slot reset drops on the clock edge after power stops being good or the host reset goes low. It rises only after a release delay of whole milliseconds, during which power must stay good, the host reset must stay high and the clock-enable pad must read high. A minimum low time is also enforced on every assertion. The clock-enable pull-down is a power-good indication with one register of delay. All times are counted in clock cycles derived from a clock-frequency parameter.

Top module: `slot_reset_seq`

## Requirements
- R1: When power is not good, the slot reset output is low at the next rising clock edge. Power is good when the mode is Card Inserted and every rail flag is 1. The slot reset is also low at the next edge when the host reset is 0.
- R2: The slot reset rises on the first edge after the release qualifier has been sampled true on REL_CYC consecutive edges, where REL_CYC = (CLK_HZ/1000)*RELEASE_DELAY_MS. The qualifier is: power good, host reset high, and clock-enable sense high.
- R3: Each time the slot reset falls from high, or the block reset is applied, a hold of MIN_CYC = (CLK_HZ/1000)*MIN_PULSE_US/1000 cycles is loaded. The slot reset cannot rise before that hold has counted down to zero.
- R4: The clock-enable pull-down output is 1 on the edge after power is not good and 0 on the edge after power is good. It is 0 whenever the slot reset is high.
- R5: While the clock-enable sense input reads 0, the slot reset is not released. The release count starts again once the sense reads 1.
- R6: Mode encoding on mode_i is 0 off, 1 shutdown, 2 no card, 3 standby, 4 card inserted. Codes 5 to 7 count as not powered.
- R7: Any loss of the release qualifier during the countdown clears the count. The full REL_CYC count is then required again.
- R8: While rst_n is low at a clock edge, the slot reset is low, the clock-enable pull-down is 1 and the hold of R3 is reloaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, frequency CLK_HZ |
| rst_n | input | 1 | Synchronous active-low block reset |
| mode_i | input | 3 | Slot power mode (encoding in R6) |
| rail_ok_i | input | N_RAILS | Per-rail output-within-tolerance flags |
| host_rst_n_i | input | 1 | Host system reset, active low |
| clken_sense_i | input | 1 | Level read back from the clock-enable pad |
| slot_rst_n_o | output | 1 | Slot reset to the card, active low |
| clken_pull_o | output | 1 | 1 drives the clock-enable pad low, 0 releases it |

## Verification
The hardest case to reach is a release held back by the minimum low time rather than by the release delay. At real settings the delay is always far longer than the hold. The bench therefore builds the block with CLK_HZ of 100 kHz, a 2 ms release delay (200 cycles) and a 3 ms hold (300 cycles). It drops one rail for a single cycle and then restores it, so the release must land exactly at the hold bound. It also drops a rail during a countdown that began while the reset was already low, so there the release lands exactly at the delay bound.

// File: rtl/slotseq_pkg.sv
// Package: shared mode encoding for the slot reset sequencer.
// Assumes the slot power controller presents its mode as a 3-bit code.
package slotseq_pkg;
    typedef enum logic [2:0] {
        MODE_OFF      = 3'd0,
        MODE_SHUTDOWN = 3'd1,
        MODE_NO_CARD  = 3'd2,
        MODE_STANDBY  = 3'd3,
        MODE_CARD_IN  = 3'd4
    } slot_mode_t;
endpackage

// File: rtl/slotseq_pwrgood.sv
// Module: decodes slot power-good from mode and rail flags, and registers
// the clock-enable pull-down (released only while power is good).
// Assumes the rail flags are already synchronous to clk.
module slotseq_pwrgood
    import slotseq_pkg::*;
#(
    parameter int N_RAILS = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [2:0]         mode_i,
    input  logic [N_RAILS-1:0] rail_ok_i,
    output logic               pg_o,
    output logic               clken_pull_o
);
    logic mode_on;
    logic rails_on;

    // Purpose: power good only in Card Inserted with every rail in tolerance.
    always_comb begin
        mode_on  = (mode_i == MODE_CARD_IN);
        rails_on = &rail_ok_i;
        pg_o     = mode_on && rails_on;
    end

    // Purpose: one-register power-good indication on the clock-enable pad.
    always_ff @(posedge clk) begin
        if (!rst_n) clken_pull_o <= 1'b1;
        else        clken_pull_o <= !pg_o;
    end

    AST_PULL_AFTER_LOSS: assert property (@(posedge clk) disable iff (!rst_n)
        !pg_o |=> clken_pull_o); // R4
endmodule

// File: rtl/slotseq_hold_timer.sv
// Module: loadable down-counter enforcing the minimum low time of the slot reset.
// Assumes load_i pulses for one cycle when the reset falls; COUNT may be zero.
module slotseq_hold_timer #(
    parameter int COUNT = 5000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load_i,
    output logic done_o
);
    localparam int W = $clog2(COUNT + 2);
    logic [W-1:0] cnt_q;

    // Purpose: reload on reset or load, otherwise count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n || load_i)  cnt_q <= W'(COUNT);
        else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
    end

    assign done_o = (cnt_q == '0);

    AST_HOLD_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= W'(COUNT)); // R3
endmodule

// File: rtl/slotseq_release_timer.sv
// Module: saturating up-counter measuring consecutive qualified cycles
// before the slot reset may be released. Any unqualified cycle clears it.
module slotseq_release_timer #(
    parameter int COUNT = 500000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear_i,
    input  logic qualify_i,
    output logic full_o
);
    localparam int W = $clog2(COUNT + 2);
    logic [W-1:0] cnt_q;

    // Purpose: count qualified cycles, restart on any loss or clear.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i || !qualify_i) cnt_q <= '0;
        else if (cnt_q != W'(COUNT))         cnt_q <= cnt_q + 1'b1;
    end

    assign full_o = (cnt_q == W'(COUNT));

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= W'(COUNT)); // R2
    AST_RESTART_ON_LOSS: assert property (@(posedge clk) disable iff (!rst_n)
        !qualify_i |=> !full_o || (COUNT == 0)); // R7
endmodule

// File: rtl/slot_reset_seq.sv
// Module: top of the slot reset and clock-enable sequencer. Asserts the slot
// reset on the edge after power or host reset is lost, and releases it after a
// qualified delay and a minimum low time. Assumes all inputs are synchronous.
module slot_reset_seq #(
    parameter int CLK_HZ           = 50_000_000,
    parameter int RELEASE_DELAY_MS = 10,
    parameter int MIN_PULSE_US     = 100,
    parameter int N_RAILS          = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [2:0]         mode_i,
    input  logic [N_RAILS-1:0] rail_ok_i,
    input  logic               host_rst_n_i,
    input  logic               clken_sense_i,
    output logic               slot_rst_n_o,
    output logic               clken_pull_o
);
    localparam int CYC_PER_MS = CLK_HZ / 1000;
    localparam int REL_CYC    = CYC_PER_MS * RELEASE_DELAY_MS;
    localparam int MIN_CYC    = (CYC_PER_MS * MIN_PULSE_US) / 1000;

    logic pg;
    logic drop;
    logic qualify;
    logic slot_q;
    logic hold_done;
    logic rel_full;

    slotseq_pwrgood #(.N_RAILS(N_RAILS)) u_pwrgood (
        .clk          (clk),
        .rst_n        (rst_n),
        .mode_i       (mode_i),
        .rail_ok_i    (rail_ok_i),
        .pg_o         (pg),
        .clken_pull_o (clken_pull_o)
    );

    // Purpose: assertion and release conditions.
    always_comb begin
        drop    = !pg || !host_rst_n_i;
        qualify = pg && host_rst_n_i && clken_sense_i;
    end

    slotseq_hold_timer #(.COUNT(MIN_CYC)) u_hold (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (slot_q && drop),
        .done_o (hold_done)
    );

    slotseq_release_timer #(.COUNT(REL_CYC)) u_release (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear_i   (slot_q),
        .qualify_i (qualify),
        .full_o    (rel_full)
    );

    // Purpose: slot reset state, low on loss, high after delay and hold.
    always_ff @(posedge clk) begin
        if (!rst_n)                              slot_q <= 1'b0;
        else if (drop)                           slot_q <= 1'b0;
        else if (!slot_q && rel_full && hold_done) slot_q <= 1'b1;
    end

    assign slot_rst_n_o = slot_q;

    AST_DROP_ASSERTS: assert property (@(posedge clk) disable iff (!rst_n)
        drop |=> !slot_rst_n_o); // R1
    AST_RELEASE_AFTER_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(slot_rst_n_o) |-> $past(rel_full) && $past(clken_sense_i)); // R2
    AST_MIN_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        !hold_done |-> !slot_rst_n_o); // R3
    AST_RELEASED_PAD_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        slot_rst_n_o |-> !clken_pull_o); // R4
endmodule

// File: tb/slot_reset_seq_tb.sv
// Bench: small configuration (200-cycle release, 300-cycle hold), with a pad
// model in which the clock-enable line reads low when pulled or held by the host.
module slot_reset_seq_tb;
    localparam int CLK_HZ = 100_000;
    localparam int REL_MS = 2;
    localparam int MIN_US = 3000;
    localparam int REL    = (CLK_HZ / 1000) * REL_MS;
    localparam int MINC   = (CLK_HZ / 1000) * MIN_US / 1000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] mode = 3'd4;
    logic [2:0] rails = 3'b111;
    logic       host_rst_n = 1'b1;
    logic       host_hold = 1'b0;
    logic       sense;
    logic       slot_rst_n;
    logic       pull;
    int         n_run = 0;
    int         n_fail = 0;

    always #10 clk = ~clk;
    assign sense = ~pull & ~host_hold;

    slot_reset_seq #(.CLK_HZ(CLK_HZ), .RELEASE_DELAY_MS(REL_MS),
                     .MIN_PULSE_US(MIN_US), .N_RAILS(3)) u_dut (
        .clk(clk), .rst_n(rst_n), .mode_i(mode), .rail_ok_i(rails),
        .host_rst_n_i(host_rst_n), .clken_sense_i(sense),
        .slot_rst_n_o(slot_rst_n), .clken_pull_o(pull));

    task automatic chk(input int got, input int exp, input string tag);
        n_run++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", tag, got, exp);
        end
    endtask

    task automatic edges(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    // Counts rising edges from now until the slot reset reads high.
    task automatic measure(output int n);
        n = 0;
        do begin
            @(posedge clk); #1; n++;
        end while (!slot_rst_n && n < 2000);
        @(negedge clk);
    endtask

    task automatic go_low_settled();
        mode = 3'd3;
        edges(MINC + 5);
    endtask

    initial begin
        int n;
        int pg;
        edges(3);
        chk(slot_rst_n, 0, "R8 reset slot low");
        chk(pull, 1, "R8 reset pull high");
        rst_n = 1'b1;
        measure(n);
        chk(n, (MINC + 1 > REL + 2) ? MINC + 1 : REL + 2, "R2/R3/R8 first release");
        chk(pull, 0, "R4 released pad free");

        // R1 + R3: single-cycle rail glitch, hold bound
        rails = 3'b110;
        edges(1);
        chk(slot_rst_n, 0, "R1 rail drop");
        chk(pull, 1, "R4 pull on loss");
        rails = 3'b111;
        measure(n);
        chk(n, MINC + 1, "R3 hold-bound release");

        // R1: surprise removal
        mode = 3'd2;
        edges(1);
        chk(slot_rst_n, 0, "R1 card removal");
        edges(MINC + 5);
        mode = 3'd4;
        measure(n);
        chk(n, REL + 2, "R2 delay-bound release");

        // R1 + R2: host reset low then high
        host_rst_n = 1'b0;
        edges(1);
        chk(slot_rst_n, 0, "R1 host reset");
        chk(pull, 0, "R4 pad free while power good");
        edges(MINC + 5);
        host_rst_n = 1'b1;
        measure(n);
        chk(n, REL + 1, "R2 host reset release");

        // R5: host holds the clock-enable pad low
        go_low_settled();
        host_hold = 1'b1;
        mode = 3'd4;
        edges(REL * 2);
        chk(slot_rst_n, 0, "R5 held pad blocks release");
        host_hold = 1'b0;
        measure(n);
        chk(n, REL + 1, "R5 release after pad freed");

        // R7: loss during the countdown restarts it
        go_low_settled();
        mode = 3'd4;
        edges(100);
        chk(slot_rst_n, 0, "R7 still counting");
        rails = 3'b101;
        edges(1);
        rails = 3'b111;
        measure(n);
        chk(n, REL + 2, "R7 restarted countdown");

        // R6 + R4 + R1: sweep all mode codes and rail patterns
        for (int m = 0; m < 8; m++) begin
            for (int r = 0; r < 8; r++) begin
                mode = 3'(m);
                rails = 3'(r);
                edges(2);
                pg = (m == 4 && r == 7) ? 1 : 0;
                chk(pull, 1 - pg, $sformatf("R6/R4 pull mode %0d rails %0d", m, r));
                if (pg == 0) chk(slot_rst_n, 0, $sformatf("R1 low mode %0d rails %0d", m, r));
            end
        end

        // R8: block reset while released
        mode = 3'd4; rails = 3'b111;
        measure(n);
        rst_n = 1'b0;
        edges(1);
        chk(slot_rst_n, 0, "R8 block reset slot low");
        chk(pull, 1, "R8 block reset pull high");
        rst_n = 1'b1;
        measure(n);
        chk(n, MINC + 1, "R8 hold reloaded by reset");

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule